// File: doc/BRIEF.md
# PLL Grant and Automatic Clock Switchover Controller

This controller sits in a slow reference clock domain and decides whether a times-four PLL fed by the internal oscillator may be powered. It then moves the system clock select from the direct oscillator to the PLL output once the PLL has had time to lock. A grant needs four things at once: the software enable bit, a primary source select, an oscillator configuration in one of the two internal-PLL settings, and an internal oscillator frequency of 4 MHz or 8 MHz. Multiplying by four then gives 16 MHz or 32 MHz. The analog PLL is not part of the block. Its start-up time, nominally 2 ms, is modelled by a counter of reference ticks.

After a grant the core keeps running on the direct oscillator while the lock counter runs. When the count completes, the select moves to the PLL with no software step. If the grant is lost for any reason, the select falls back to the direct oscillator in the same cycle. The next grant then starts a fresh, full lock wait. A ready flag shows whether the lock wait has completed.

Top module: `pll_switch_ctrl`

## Requirements
- R1: While rst_n is low, and after its release until a grant is seen, pll_pwr_en, clk_sel_pll and pll_ready are all 0.
- R2: pll_pwr_en is 1 in the same cycle exactly when pll_en_sw is 1, src_sel is 2'b00, osc_cfg is 3'b010 or 3'b011, and freq_sel is 3'b110 or 3'b111. All other combinations give 0.
- R3: From the first rising edge at which the grant of R2 is sampled true, clk_sel_pll stays 0 for LOCK_TICKS edges. It becomes 1 after edge number LOCK_TICKS+1, provided the grant holds throughout.
- R4: Once clk_sel_pll is 1, it stays 1 with no further input for as long as the grant holds.
- R5: When the grant is lost (the enable clears or any field stops qualifying), clk_sel_pll is 0 in that same cycle.
- R6: A grant that is lost and then restored, including a brief drop of the enable during the lock wait, restarts the lock wait from zero. The full R3 delay then applies again.
- R7: pll_ready becomes 1 together with clk_sel_pll at the end of the lock wait, and it is 1 whenever clk_sel_pll is 1.
- R8: pll_ready returns to 0 after the first rising edge at which the grant is sampled false.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pll_en_sw | input | 1 | Software PLL enable bit |
| src_sel | input | 2 | System clock source select (2'b00 = primary) |
| osc_cfg | input | 3 | Oscillator configuration field (3'b010 / 3'b011 = internal oscillator with PLL) |
| freq_sel | input | 3 | Internal oscillator frequency select (3'b110 = 4 MHz, 3'b111 = 8 MHz) |
| pll_pwr_en | output | 1 | Powers the PLL while the grant holds |
| clk_sel_pll | output | 1 | 1 = system clock from the PLL, 0 = direct oscillator |
| pll_ready | output | 1 | Lock wait has completed |

## Verification
The bench sweeps every combination of the three configuration fields with the enable set. At the start and end of each lock window it checks power and select; a wrong decode would grant the PLL to an unsupported frequency or mode. It counts edges to the exact switch cycle, which catches an off-by-one counter that switches early onto an unlocked PLL or one tick late. It drops the enable briefly during locking and expects a full new wait, which catches a counter that resumes instead of clearing. It removes a field while running and expects the select to fall in the same cycle, which catches a registered fallback that leaves the core on a PLL that is shutting down.

// File: rtl/pll_switch_pkg.sv
package pll_switch_pkg;

  localparam int SRC_W  = 2;
  localparam int CFG_W  = 3;
  localparam int FREQ_W = 3;

  localparam logic [SRC_W-1:0]  SRC_PRIMARY   = 2'b00;
  localparam logic [CFG_W-1:0]  CFG_INTPLL_A  = 3'b010;
  localparam logic [CFG_W-1:0]  CFG_INTPLL_B  = 3'b011;
  localparam logic [FREQ_W-1:0] FREQ_4MHZ     = 3'b110;
  localparam logic [FREQ_W-1:0] FREQ_8MHZ     = 3'b111;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_LOCK = 2'd1,
    SW_RUN  = 2'd2
  } sw_state_e;

  function automatic logic mode_allows_pll(input logic [SRC_W-1:0] src,
                                           input logic [CFG_W-1:0] cfg);
    return (src == SRC_PRIMARY) && ((cfg == CFG_INTPLL_A) || (cfg == CFG_INTPLL_B));
  endfunction

  function automatic logic freq_allows_pll(input logic [FREQ_W-1:0] fs);
    return (fs == FREQ_4MHZ) || (fs == FREQ_8MHZ);
  endfunction

endpackage

// File: rtl/pll_cfg_qual.sv
module pll_cfg_qual
  import pll_switch_pkg::*;
(
  input  logic              en_sw,
  input  logic [SRC_W-1:0]  src_sel,
  input  logic [CFG_W-1:0]  osc_cfg,
  input  logic [FREQ_W-1:0] freq_sel,
  output logic              mode_ok,
  output logic              freq_ok,
  output logic              grant
);

  always_comb begin
    mode_ok = mode_allows_pll(src_sel, osc_cfg);
    freq_ok = freq_allows_pll(freq_sel);
    grant   = en_sw & mode_ok & freq_ok;
  end

endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_TICKS = 64,
  localparam int CNT_W     = $clog2(LOCK_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_TICKS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);  // R3

  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));  // R6

endmodule

// File: rtl/pll_switch_fsm.sv
module pll_switch_fsm
  import pll_switch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      grant,
  input  logic      lock_done,
  output sw_state_e state,
  output logic      timer_run
);

  sw_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      SW_IDLE: if (grant) nxt = SW_LOCK;
      SW_LOCK: if (!grant) nxt = SW_IDLE;
               else if (lock_done) nxt = SW_RUN;
      SW_RUN:  if (!grant) nxt = SW_IDLE;
      default: nxt = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SW_IDLE;
    else        state <= nxt;
  end

  assign timer_run = (state == SW_LOCK) && grant;

  AST_RUN_ONLY_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SW_RUN) && ($past(state) != SW_RUN) |-> $past(lock_done));  // R3

  AST_NO_IDLE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == SW_IDLE) |-> (state != SW_RUN));  // R6

endmodule

// File: rtl/pll_switch_ctrl.sv
module pll_switch_ctrl
  import pll_switch_pkg::*;
#(
  parameter int LOCK_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pll_en_sw,
  input  logic [1:0] src_sel,
  input  logic [2:0] osc_cfg,
  input  logic [2:0] freq_sel,
  output logic       pll_pwr_en,
  output logic       clk_sel_pll,
  output logic       pll_ready
);

  localparam int CNT_W = $clog2(LOCK_TICKS + 1);

  logic             mode_ok;
  logic             freq_ok;
  logic             grant;
  logic             timer_run;
  logic             lock_done;
  logic [CNT_W-1:0] lock_cnt;
  sw_state_e        state;

  pll_cfg_qual u_qual (
    .en_sw   (pll_en_sw),
    .src_sel (src_sel),
    .osc_cfg (osc_cfg),
    .freq_sel(freq_sel),
    .mode_ok (mode_ok),
    .freq_ok (freq_ok),
    .grant   (grant)
  );

  pll_lock_timer #(.LOCK_TICKS(LOCK_TICKS)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (timer_run),
    .cnt  (lock_cnt),
    .done (lock_done)
  );

  pll_switch_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .lock_done(lock_done),
    .state    (state),
    .timer_run(timer_run)
  );

  assign pll_pwr_en  = grant;
  assign pll_ready   = (state == SW_RUN);
  assign clk_sel_pll = pll_ready && grant;

  AST_SEL_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_pll |-> pll_pwr_en);  // R5

  AST_SEL_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_pll |-> pll_ready);  // R7

  AST_GRANT_NEEDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwr_en |-> (mode_ok && freq_ok && pll_en_sw));  // R2

  AST_DROP_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(grant) |-> !pll_ready);  // R8

  AST_READY_ROSE_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_ready) |-> $past(lock_cnt) == CNT_W'(LOCK_TICKS - 1));  // R3

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clk_sel_pll) && $past(grant) && grant |-> clk_sel_pll);  // R4

endmodule

// File: tb/test_pll_switch_ctrl.sv
module test_pll_switch_ctrl;

  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_en_sw = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [2:0] osc_cfg = 3'b000;
  logic [2:0] freq_sel = 3'b000;
  logic       pll_pwr_en;
  logic       clk_sel_pll;
  logic       pll_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #5 clk = ~clk;

  pll_switch_ctrl #(.LOCK_TICKS(N)) i_pll_switch_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_en_sw  (pll_en_sw),
    .src_sel    (src_sel),
    .osc_cfg    (osc_cfg),
    .freq_sel   (freq_sel),
    .pll_pwr_en (pll_pwr_en),
    .clk_sel_pll(clk_sel_pll),
    .pll_ready  (pll_ready)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic want_grant(input logic en, input int s, input int c, input int f);
    return en && (s == 0) && ((c >> 1) == 1) && (f >= 6);
  endfunction

  task automatic set_inputs(input logic en, input int s, input int c, input int f);
    pll_en_sw = en;
    src_sel   = 2'(s);
    osc_cfg   = 3'(c);
    freq_sel  = 3'(f);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    logic g;
    repeat (3) @(negedge clk);
    chk("R1 pwr in reset", pll_pwr_en, 1'b0);
    chk("R1 sel in reset", clk_sel_pll, 1'b0);
    chk("R1 ready in reset", pll_ready, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sel after reset", clk_sel_pll, 1'b0);
    chk("R1 ready after reset", pll_ready, 1'b0);

    // R2 R3: sweep every field combination with the enable set
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int f = 0; f < 8; f++) begin
          set_inputs(1'b0, 0, 0, 0);
          @(negedge clk);
          set_inputs(1'b1, s, c, f);
          g = want_grant(1'b1, s, c, f);
          #1;
          chk("R2 pwr decode", pll_pwr_en, g);
          chk("R3 sel before first edge", clk_sel_pll, 1'b0);
          for (int e = 1; e <= N + 1; e++) begin
            @(negedge clk);
            if (e == N) chk("R3 sel still direct at last wait edge", clk_sel_pll, 1'b0);
            if (e == N + 1) begin
              chk("R3 sel switched after lock wait", clk_sel_pll, g);
              chk("R7 ready with switch", pll_ready, g);
            end
          end
        end
      end
    end

    // R2: enable cleared blocks every qualifying combination
    for (int c = 2; c < 4; c++) begin
      for (int f = 6; f < 8; f++) begin
        set_inputs(1'b0, 0, c, f);
        #1;
        chk("R2 pwr off with enable clear", pll_pwr_en, 1'b0);
        repeat (N + 2) @(negedge clk);
        chk("R2 sel off with enable clear", clk_sel_pll, 1'b0);
      end
    end

    // R4: select holds for a long run
    set_inputs(1'b1, 0, 3, 7);
    repeat (N + 1) @(negedge clk);
    chk("R4 switched", clk_sel_pll, 1'b1);
    repeat (40) @(negedge clk);
    chk("R4 sel holds", clk_sel_pll, 1'b1);
    chk("R7 ready holds", pll_ready, 1'b1);

    // R5 R8: frequency field stops qualifying while running
    freq_sel = 3'b101;
    #1;
    chk("R5 sel falls same cycle on field loss", clk_sel_pll, 1'b0);
    chk("R5 pwr falls on field loss", pll_pwr_en, 1'b0);
    chk("R8 ready still set before edge", pll_ready, 1'b1);
    @(negedge clk);
    chk("R8 ready cleared after edge", pll_ready, 1'b0);
    freq_sel = 3'b110;
    #1;
    chk("R6 no instant return to pll", clk_sel_pll, 1'b0);
    for (int e = 1; e <= N + 1; e++) begin
      @(negedge clk);
      if (e == N) chk("R6 full wait after field return", clk_sel_pll, 1'b0);
      if (e == N + 1) chk("R6 switched after field return", clk_sel_pll, 1'b1);
    end

    // R5: enable cleared while running
    pll_en_sw = 1'b0;
    #1;
    chk("R5 sel falls same cycle on enable clear", clk_sel_pll, 1'b0);
    @(negedge clk);
    chk("R8 ready cleared after enable clear", pll_ready, 1'b0);

    // R6: brief enable drop in the middle of the lock wait
    set_inputs(1'b1, 0, 2, 6);
    repeat (N - 2) @(negedge clk);
    pll_en_sw = 1'b0;
    @(negedge clk);
    pll_en_sw = 1'b1;
    for (int e = 1; e <= N + 1; e++) begin
      @(negedge clk);
      if (e == N) chk("R6 restart waits full lock", clk_sel_pll, 1'b0);
      if (e == N + 1) chk("R6 restart switches", clk_sel_pll, 1'b1);
    end

    // R6: source select leaves primary for one cycle during locking
    pll_en_sw = 1'b0;
    @(negedge clk);
    pll_en_sw = 1'b1;
    repeat (N - 1) @(negedge clk);
    src_sel = 2'b01;
    @(negedge clk);
    src_sel = 2'b00;
    for (int e = 1; e <= N + 1; e++) begin
      @(negedge clk);
      if (e == N) chk("R6 source glitch restarts wait", clk_sel_pll, 1'b0);
      if (e == N + 1) chk("R6 source glitch then switch", clk_sel_pll, 1'b1);
    end

    // R1: reset while running
    rst_n = 1'b0;
    #1;
    chk("R1 ready cleared by reset", pll_ready, 1'b0);
    chk("R1 sel cleared by reset", clk_sel_pll, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 1; e <= N + 1; e++) begin
      @(negedge clk);
      if (e == N) chk("R3 wait after reset", clk_sel_pll, 1'b0);
      if (e == N + 1) chk("R3 switch after reset", clk_sel_pll, 1'b1);
    end

    finish_run();
  end

endmodule